// File: doc/BRIEF.md
# Page-Table Base Write Exit Filter

This block decides whether a guest write of a new page-table base value has to trap to the hypervisor. It holds up to four target values and a run-time target count. On every write event it compares the written operand against the active targets in parallel. One cycle later it reports an exit request unless one of the active targets matches.

A separate entry-check strobe samples whether the programmed count is legal. A count above four marks the configuration as invalid. Targets and the count are loaded through a plain address/data/valid configuration port.

Reset leaves the count at zero, so every write traps until software programs the block.

Top module: `pgbase_exit_filter`

## Requirements
- R1: After reset the count is 0, all targets are 0, `res_valid` and `chk_valid` are low, and a write event with any operand (including 0) requests an exit.
- R2: `res_valid` is high for exactly the cycle after each cycle in which `wr_evt` is high, and low in every other cycle; `res_exit` holds the decision for that event.
- R3: When the count is 0, every write event requests an exit (`res_exit`=1).
- R4: A write event whose operand equals target k, with k less than the count, gives `res_exit`=0.
- R5: A target at index k, with k greater than or equal to the count, takes no part in matching, even if it holds the operand.
- R6: An operand that equals none of the active targets gives `res_exit`=1.
- R7: One cycle after `entry_req`, `chk_valid` pulses high and `chk_fail` is 1 exactly when the count is greater than 4 (unsigned 32-bit compare).
- R8: Configuration address map: addresses 0 to 3 load target 0 to 3 from all 64 data bits; address 4 loads the count from data bits 31:0; addresses 5 to 7 change nothing.
- R9: If a configuration write and a write event fall in the same cycle, the event is judged against the contents held before that write.
- R10: With a count greater than 4, all four targets are active for matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| wr_evt | input | 1 | Guest page-table base write event |
| wr_operand | input | 64 | Value the guest writes |
| res_valid | output | 1 | Decision valid pulse |
| res_exit | output | 1 | 1 = trap to hypervisor |
| entry_req | input | 1 | Entry-check strobe |
| chk_valid | output | 1 | Entry-check result valid pulse |
| chk_fail | output | 1 | 1 = count is illegal |

## Verification
The hardest cases to reach are a target that holds the operand but lies outside the active window, and a count so large that it is illegal yet still enables every target. The stimulus loads four distinct targets once. It then steps the count through 0 to 7 and 0xFFFFFFFF, and at each step it probes every target plus one value that matches none. The expected decision comes from the index compared with the count, clamped to four. A further sequence places a target reload in the same cycle as an event, to show that the old contents decide it.

// File: rtl/pgbase_exit_filter.sv
module pgbase_exit_filter #(
  parameter int SLOTS  = 4,
  parameter int VAL_W  = 64,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 3,
  parameter int LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [VAL_W-1:0]  cfg_wdata,
  input  logic              wr_evt,
  input  logic [VAL_W-1:0]  wr_operand,
  output logic              res_valid,
  output logic              res_exit,
  input  logic              entry_req,
  output logic              chk_valid,
  output logic              chk_fail
);
  localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(SLOTS);

  logic [CNT_W-1:0] cnt_q;
  logic [SLOTS-1:0] hit;
  logic             entry_bad;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cfg_we && cfg_addr == CNT_ADDR)
      cnt_q <= cfg_wdata[CNT_W-1:0];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [VAL_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val_q <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(g))
        val_q <= cfg_wdata;
    end
    assign hit[g] = (CNT_W'(g) < cnt_q) && (val_q == wr_operand);
  end

  assign entry_bad = cnt_q > CNT_W'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_exit  <= 1'b0;
      chk_valid <= 1'b0;
      chk_fail  <= 1'b0;
    end else begin
      res_valid <= wr_evt;
      chk_valid <= entry_req;
      if (wr_evt)    res_exit <= ~|hit;
      if (entry_req) chk_fail <= entry_bad;
    end
  end
endmodule

module pgbase_exit_filter_chk #(
  parameter int CNT_W = 32,
  parameter int LIMIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_evt,
  input logic             entry_req,
  input logic             res_valid,
  input logic             res_exit,
  input logic             chk_valid,
  input logic             chk_fail,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  evt_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> res_valid);
  // R2
  no_spurious_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> !res_valid);
  // R3
  zero_count_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && cnt_q == '0) |=> res_exit);
  // R7
  entry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |=> (chk_valid && (chk_fail == ($past(cnt_q) > CNT_W'(LIMIT)))));
endmodule

bind pgbase_exit_filter pgbase_exit_filter_chk #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .entry_req(entry_req),
  .res_valid(res_valid), .res_exit(res_exit), .chk_valid(chk_valid),
  .chk_fail(chk_fail), .cnt_q(cnt_q)
);

// File: tb/test_pgbase_exit_filter.sv
`timescale 1ns/1ps
module test_pgbase_exit_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic wr_evt = 1'b0;
  logic [63:0] wr_operand = '0;
  logic entry_req = 1'b0;
  logic res_valid, res_exit, chk_valid, chk_fail;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgbase_exit_filter i_pgbase_exit_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_evt(wr_evt), .wr_operand(wr_operand),
    .res_valid(res_valid), .res_exit(res_exit), .entry_req(entry_req),
    .chk_valid(chk_valid), .chk_fail(chk_fail)
  );

  function automatic logic [63:0] tval(int i);
    return 64'hA5C3_0000_0000_0000 + 64'(i) * 64'h0001_0203_0405_0607;
  endfunction

  localparam logic [63:0] MISS = 64'hDEAD_BEEF_0BAD_F00D;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic evt(input logic [63:0] op, output logic v, output logic e);
    @(negedge clk); wr_evt = 1; wr_operand = op;
    @(negedge clk); wr_evt = 0; v = res_valid; e = res_exit;
  endtask

  task automatic entry(output logic v, output logic f);
    @(negedge clk); entry_req = 1;
    @(negedge clk); entry_req = 0; v = chk_valid; f = chk_fail;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic v, e;
    logic [31:0] counts [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 32'hFFFF_FFFF};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(res_valid == 0, "R1 res_valid", res_valid, 0);
    check(chk_valid == 0, "R1 chk_valid", chk_valid, 0);
    evt(64'h0, v, e);
    check(v == 1 && e == 1, "R1 zero operand traps after reset", {v, e}, 2'b11);
    entry(v, e);
    check(v == 1 && e == 0, "R1 entry check after reset", {v, e}, 2'b10);

    for (int i = 0; i < 4; i++) cfg(3'(i), tval(i));

    foreach (counts[c]) begin
      int active;
      active = (counts[c] > 4) ? 4 : int'(counts[c]);
      cfg(3'd4, {32'hFFFF_0000, counts[c]});
      for (int j = 0; j < 4; j++) begin
        bit exp_exit;
        exp_exit = !(j < active);
        evt(tval(j), v, e);
        check(v == 1, "R2 valid pulse", v, 1);
        if (counts[c] == 0)     check(e == 1, "R3 zero count traps", e, 1);
        else if (exp_exit)      check(e == 1, "R5 inactive slot ignored", e, 1);
        else if (counts[c] > 4) check(e == 0, "R10 all slots active", e, 0);
        else                    check(e == 0, "R4 active match no exit", e, 0);
        @(negedge clk);
        check(res_valid == 0, "R2 single-cycle pulse", res_valid, 0);
      end
      evt(MISS, v, e);
      check(v == 1 && e == 1, "R6 miss traps", {v, e}, 2'b11);
      entry(v, e);
      check(v == 1 && e == (counts[c] > 4), "R7 entry check", {v, e}, {1'b1, counts[c] > 4});
    end

    // R8 address map: 5..7 ignored
    cfg(3'd4, 64'd2);
    cfg(3'd5, 64'd7);
    cfg(3'd6, MISS);
    cfg(3'd7, 64'd9);
    entry(v, e);
    check(e == 0, "R8 count unchanged by addr 5-7", e, 0);
    evt(tval(1), v, e);
    check(e == 0, "R8 slot1 still active", e, 0);
    evt(tval(2), v, e);
    check(e == 1, "R8 count still 2", e, 1);
    evt(MISS, v, e);
    check(e == 1, "R8 no slot loaded from addr 6", e, 1);

    // R9 same-cycle write and event
    cfg(3'd4, 64'd1);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = MISS;
    wr_evt = 1; wr_operand = tval(0);
    @(negedge clk);
    cfg_we = 0; wr_evt = 0;
    check(res_valid == 1 && res_exit == 0, "R9 old contents decide", {res_valid, res_exit}, 2'b10);
    evt(MISS, v, e);
    check(e == 0, "R9 new value active afterwards", e, 0);
    evt(tval(0), v, e);
    check(e == 1, "R9 old value gone", e, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule